// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits between a free-running source clock and a group of clock outputs that leave the chip. It turns the group off and on again when an active-low stop request arrives. The request may come from any clock domain. The block brings the request into the source clock domain, then changes each output only while the source clock is low. An output therefore goes quiet in the low state, and on restart its first high pulse has the full width. Each output also has a configuration enable bit. A cleared bit holds that output low whatever the stop request does. Outputs marked as free-running ignore the stop request but still obey their enable bit.

A parameter selects one of two variants. The fast-processor group has a two-stage synchronizer and keeps the clocks running for at least 100 pulses after a restart. The bus group has a one-stage synchronizer and a 10-pulse minimum. The stop request acts only when the mobile-mode select is high. With the select low, the request is ignored. The mode select is treated as a static strap.

Top module: `clk_stop_gate`

## Requirements
- R1: Every output is low whenever the source clock is low. Every high pulse of an output spans a whole high phase of the source clock, with no runt pulses.
- R2: While mobile_sel=1 and stop_n is held low, every non-free-running output stops in the low state. Outputs that are enabled and free-running keep toggling.
- R3: Off latency, measured after stop_n falls during a source low phase with the minimum run already met. The fast-processor variant delivers exactly two more output pulses before going quiet. The bus variant delivers exactly one.
- R4: On latency, measured after stop_n rises during a source low phase. In the fast-processor variant, the first output rising edge comes on the third source rising edge. In the bus variant, it comes on the second.
- R5: Once a stopped group restarts, it delivers at least the minimum number of pulses before a new stop can take effect: 100 for the fast-processor variant, 10 for the bus variant. If stop is already requested again, the group delivers exactly that number of pulses.
- R6: With mobile_sel=0, stop_n has no effect and all enabled outputs run.
- R7: out_en bit i gates clk_out bit i. When out_en[i]=0, clk_out[i] stays low whatever the state of stop_n.
- R8: Outputs flagged in FREE_MASK ignore stop_n and follow only their out_en bit.
- R9: A low pulse on stop_n that does not span a source rising edge is ignored.
- R10: While rst_n is low, all outputs are held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| mobile_sel | input | 1 | 1 = stop request honoured, 0 = ignored (static) |
| out_en | input | N_OUT | Per-output enable, 1 = output may toggle |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
Some properties are checked by the assertions on every cycle. The group is never off unless a stop request was present on the previous low phase. The group never turns off before the minimum run count is reached. In mobile_sel=0 operation the group never stops. A disabled output's enable register stays clear, and a free-running output tracks only its enable bit. Other behaviours can only be shown by the bench's scenarios, because they depend on where in the source clock the stimulus lands. These are the exact pulse counts for off latency, the rising edge on which a restart appears, the exact minimum-run count, the rejection of a short stop pulse, and the absence of runt pulses on the outputs.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic {
    GRP_CPU = 1'b0,
    GRP_PCI = 1'b1
  } clk_group_e;

  // number of synchronizer flops in front of the gate decision
  function automatic int sync_depth(clk_group_e g);
    return (g == GRP_CPU) ? 2 : 1;
  endfunction

  // pulses guaranteed after a restart before a new stop is obeyed
  function automatic int min_run(clk_group_e g);
    return (g == GRP_CPU) ? 100 : 10;
  endfunction

  // counter width able to hold 0..limit
  function automatic int cnt_width(int limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '1;
    end else begin
      stage[0] <= async_n;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign sync_n = stage[DEPTH-1];
endmodule

// File: rtl/run_window.sv
module run_window #(
  parameter int MIN_RUN = 100,
  parameter int CW      = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic run_next,
  output logic gate_on,
  output logic min_met
);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_RUN);

  logic [CW-1:0] pulse_cnt;

  // counts pulses delivered since the gate last opened, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pulse_cnt <= MIN_V;
    else if (!gate_on)     pulse_cnt <= '0;
    else if (!min_met)     pulse_cnt <= pulse_cnt + 1'b1;
  end

  assign min_met  = (pulse_cnt >= MIN_V);
  assign run_next = !stop_req || (gate_on && !min_met);

  // group state changes only on the falling edge, i.e. in the low phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b1;
    else        gate_on <= run_next;
  end

  assert_min_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_on) |-> min_met)
    else $error("group stopped before minimum run");
endmodule

// File: rtl/gate_cell.sv
module gate_cell #(
  parameter bit FREE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic run_next,
  output logic clk_out
);
  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cfg_en & (FREE | run_next);
  end

  assign clk_out = clk & en_q;

  assert_disabled_low_R7: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_en)) |-> !en_q)
    else $error("disabled output still enabled");

  if (FREE) begin : g_free_chk
    assert_free_runs_R8: assert property (@(negedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_en)) |-> en_q)
      else $error("free-running output was gated");
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int              N_OUT     = 4,
  parameter clk_group_e      GROUP     = GRP_CPU,
  parameter logic [N_OUT-1:0] FREE_MASK = '0
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic             mobile_sel,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_out
);
  localparam int SYNC_N  = sync_depth(GROUP);
  localparam int MIN_RUN = min_run(GROUP);
  localparam int CW      = cnt_width(MIN_RUN);

  logic stop_n_sync;
  logic stop_req;
  logic run_next;
  logic gate_on;
  logic min_met;

  stop_sync #(.DEPTH(SYNC_N)) u_sync (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .async_n (stop_n),
    .sync_n  (stop_n_sync)
  );

  assign stop_req = mobile_sel & ~stop_n_sync;

  run_window #(.MIN_RUN(MIN_RUN), .CW(CW)) u_win (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .run_next (run_next),
    .gate_on  (gate_on),
    .min_met  (min_met)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_cell
    gate_cell #(.FREE(FREE_MASK[g])) u_cell (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .cfg_en   (out_en[g]),
      .run_next (run_next),
      .clk_out  (clk_out[g])
    );
  end

  assert_off_needs_request_R2: assert property (@(negedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && !gate_on) |-> $past(stop_req))
    else $error("group off without stop request");

  assert_desktop_runs_R6: assert property (@(negedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && !$past(mobile_sel)) |-> gate_on)
    else $error("group stopped with mobile mode off");
endmodule

// File: tb/clk_stop_gate_test.sv
module clk_stop_gate_test;
  import clk_stop_pkg::*;

  localparam int CLK_PERIOD = 10;

  // {mobile, stop_n, en[3:0], exp_cpu[3:0], exp_pci[1:0]}
  localparam logic [11:0] VEC [8] = '{
    12'b1_1_1111_1111_11,
    12'b1_0_1111_0000_10,
    12'b0_0_1111_1111_11,
    12'b0_0_0101_0101_01,
    12'b1_1_1010_1010_10,
    12'b1_0_1010_0000_10,
    12'b1_1_0000_0000_00,
    12'b1_1_1111_1111_11
  };
  string tags [8] = '{"R2", "R2", "R6", "R7", "R7", "R8", "R7", "R2"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_n = 1'b1;
  logic       mobile = 1'b1;
  logic [3:0] en = 4'hF;
  logic [3:0] cpu_out;
  logic [1:0] pci_out;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  int cc [4] = '{0, 0, 0, 0};
  int pc [2] = '{0, 0};
  int base_c [4];
  int base_p [2];
  logic [3:0] early_c;
  logic [1:0] early_p;

  clk_stop_gate #(.N_OUT(4), .GROUP(GRP_CPU)) uut (
    .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .mobile_sel(mobile),
    .out_en(en), .clk_out(cpu_out));

  clk_stop_gate #(.N_OUT(2), .GROUP(GRP_PCI), .FREE_MASK(2'b10)) uut_pci (
    .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .mobile_sel(mobile),
    .out_en(en[1:0]), .clk_out(pci_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // pulse counter and runt monitor (R1)
  always begin
    @(posedge clk);
    #1;
    early_c = cpu_out;
    early_p = pci_out;
    for (int i = 0; i < 4; i++) if (cpu_out[i]) cc[i]++;
    for (int i = 0; i < 2; i++) if (pci_out[i]) pc[i]++;
    #3;
    if (cpu_out != early_c || pci_out != early_p) glitches++;
    #3;
    if (cpu_out != 4'b0 || pci_out != 2'b0) glitches++;
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic at_low();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic snap();
    for (int i = 0; i < 4; i++) base_c[i] = cc[i];
    for (int i = 0; i < 2; i++) base_p[i] = pc[i];
  endtask

  function automatic int dc(int i);
    return cc[i] - base_c[i];
  endfunction

  function automatic int dp(int i);
    return pc[i] - base_p[i];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first_c;
    int first_p;
    // R10: outputs quiet during reset
    snap();
    wait_cyc(6);
    for (int i = 0; i < 4; i++) chk("R10 cpu", dc(i), 0);
    for (int i = 0; i < 2; i++) chk("R10 pci", dp(i), 0);
    at_low();
    rst_n = 1'b1;

    // vector table
    for (int r = 0; r < 8; r++) begin
      logic [11:0] v;
      v = VEC[r];
      at_low();
      mobile = v[11];
      stop_n = v[10];
      en     = v[9:6];
      wait_cyc(110);
      snap();
      wait_cyc(8);
      for (int i = 0; i < 4; i++) chk(tags[r], dc(i), v[2+i] ? 8 : 0);
      for (int i = 0; i < 2; i++) chk(tags[r], dp(i), v[i] ? 8 : 0);
    end

    // R3: off latency
    at_low();
    snap();
    stop_n = 1'b0;
    wait_cyc(10);
    chk("R3 cpu0", dc(0), 2);
    chk("R3 cpu3", dc(3), 2);
    chk("R3 pci0", dp(0), 1);
    chk("R8 pci1 free", dp(1), 10);

    // R4: on latency
    at_low();
    stop_n = 1'b1;
    first_c = 0;
    first_p = 0;
    for (int e = 1; e <= 5; e++) begin
      @(posedge clk);
      #2;
      if (first_c == 0 && cpu_out[0]) first_c = e;
      if (first_p == 0 && pci_out[0]) first_p = e;
    end
    chk("R4 cpu", first_c, 3);
    chk("R4 pci", first_p, 2);

    // R5: minimum run after restart with stop re-requested
    wait_cyc(120);
    at_low();
    stop_n = 1'b0;
    wait_cyc(10);
    at_low();
    snap();
    stop_n = 1'b1;
    wait_cyc(4);
    at_low();
    stop_n = 1'b0;
    wait_cyc(150);
    chk("R5 cpu", dc(0), 100);
    chk("R5 pci", dp(0), 10);

    // R9: short stop pulse within one high/low span
    at_low();
    stop_n = 1'b1;
    wait_cyc(120);
    @(posedge clk);
    #2;
    snap();
    stop_n = 1'b0;
    #2;
    stop_n = 1'b1;
    wait_cyc(10);
    chk("R9 cpu", dc(0), 10);
    chk("R9 pci", dp(0), 10);

    // R1: no runt or misplaced pulse seen anywhere
    chk("R1 glitches", glitches, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule